// File: doc/BRIEF.md
# Edge-Filtered Status Event Register

This block is one cell of a status reporting tree, as used by instrument remote-control logic. A live hardware status word enters on `cond_in`. Each bit has a rising-edge filter and a falling-edge filter. When a bit changes in a direction its filter allows, the matching bit of a sticky event word is set. The event word is ANDed with an enable mask and then reduced to a single summary bit, which a higher-level cell can take as one of its own condition inputs.

Software reaches the five 16-bit parts through a small register bus. The bus has a 3-bit part select, a write strobe, a read strobe and registered read data. Reading the event part returns it and clears it in the same access. An edge that lands in that same cycle is kept for the next read. Bit 15 of every part is tied to zero, so each part reads as a non-negative integer.

The reset input is asserted asynchronously. Its release is synchronised to the clock inside the block, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `stsreg_cell`

## Requirements
- R1: Bit 15 of every part reads as 0. A level or edge on `cond_in[15]` never sets an event. Bus writes never store bit 15.
- R2: Part select 0 (live) returns `cond_in` as sampled in the cycle of the read strobe. Writes to it have no effect, and reading it changes nothing.
- R3: A 0-to-1 change of a `cond_in` bit sets the matching event bit only when the matching bit of the rising filter (part select 1) is 1.
- R4: A 1-to-0 change of a `cond_in` bit sets the matching event bit only when the matching bit of the falling filter (part select 2) is 1.
- R5: A bit whose rising and falling filter bits are both 1 records a change in either direction.
- R6: Event bits are sticky. They stay set until the event part is read.
- R7: A read of the event part (part select 3) returns its value and clears it. An edge in the clearing cycle is set anyway and shows on the next read.
- R8: Bus writes to the event part have no effect.
- R9: The rising filter, the falling filter and the enable mask (part select 4) can be read and written freely. Reading them has no side effect, and a write takes effect on the next cycle.
- R10: `sum_out` is 1 exactly when some bit is set in both the event part and the enable mask. It follows those registers in the same cycle.
- R11: After reset, the event part, the enable mask, the falling filter and the edge history are all 0, and the rising filter reads 0x7FFF.
- R12: `rd_data` is valid in the cycle after a read strobe and holds until the next read strobe. Part selects 5 to 7 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_in | input | 16 | Live hardware status word, synchronous to clk |
| part_sel | input | 3 | Part select: 0 live, 1 rising filter, 2 falling filter, 3 event, 4 enable |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| sum_out | output | 1 | OR of event AND enable |

## Verification
If the edge history is stale, events appear one cycle early or late, or in the wrong direction. This shows on the next event read and, once the bit is enabled, on `sum_out` a cycle after the edge. A filter, mask or event bit that is lost or wrongly kept changes `rd_data` on the next read of that part, and changes `sum_out` as soon as an enabled bit is involved. Because the bench compares both outputs with a reference model on every cycle, any such fault is caught at the first cycle in which it becomes visible at the ports.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  typedef enum logic [2:0] {
    PART_LIVE  = 3'd0,
    PART_RISE  = 3'd1,
    PART_FALL  = 3'd2,
    PART_LATCH = 3'd3,
    PART_MASK  = 3'd4
  } part_e;

  localparam int unsigned NUM_RW_PARTS = 3;

endpackage

// File: rtl/stsreg_rstsync.sv
module stsreg_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stsreg_edge.sv
module stsreg_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_in,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] live_m,
  output logic [W-1:0] hist_q,
  output logic [W-1:0] rise_hits,
  output logic [W-1:0] fall_hits
);

  localparam logic [W-1:0] VALID = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] hist_d;

  always_comb begin
    live_m    = live_in & VALID;
    hist_d    = live_m;
    rise_hits = live_m & ~hist_q & rise_en;
    fall_hits = ~live_m & hist_q & fall_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/stsreg_latch.sv
module stsreg_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic         clr,
  output logic [W-1:0] evt_q
);

  logic [W-1:0] evt_d;
  logic [W-1:0] keep;

  always_comb begin
    keep  = clr ? '0 : evt_q;
    evt_d = keep | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_d;
    end
  end

endmodule

// File: rtl/stsreg_regs.sv
module stsreg_regs
  import stsreg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   part_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] live_m,
  input  logic [W-1:0] evt_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] mask_q,
  output logic         latch_clr,
  output logic [W-1:0] rd_data
);

  localparam logic [W-1:0] VALID = {1'b0, {(W-1){1'b1}}};
  localparam logic [2:0] CODES [NUM_RW_PARTS] = '{3'd1, 3'd2, 3'd4};
  localparam logic [W-1:0] RSTV [NUM_RW_PARTS] = '{VALID, '0, '0};

  logic [W-1:0] part_q [NUM_RW_PARTS];
  logic [W-1:0] wdata_m;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rd_d;

  assign wdata_m = wr_data & VALID;

  for (genvar g = 0; g < NUM_RW_PARTS; g++) begin : g_part
    logic         we;
    logic [W-1:0] d;
    always_comb begin
      we = wr_en && (part_sel == CODES[g]);
      d  = wdata_m;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        part_q[g] <= RSTV[g];
      end else if (we) begin
        part_q[g] <= d;
      end
    end
  end

  assign rise_q = part_q[0];
  assign fall_q = part_q[1];
  assign mask_q = part_q[2];

  always_comb begin
    case (part_sel)
      PART_LIVE:  rd_mux = live_m;
      PART_RISE:  rd_mux = rise_q;
      PART_FALL:  rd_mux = fall_q;
      PART_LATCH: rd_mux = evt_q;
      PART_MASK:  rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
    latch_clr = rd_en && (part_sel == PART_LATCH);
    rd_d      = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

endmodule

// File: rtl/stsreg_cell.sv
module stsreg_cell
  import stsreg_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_in,
  input  logic [2:0]   part_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         sum_out
);

  logic         rst_q;
  logic [W-1:0] live_m;
  logic [W-1:0] hist_q;
  logic [W-1:0] rise_hits;
  logic [W-1:0] fall_hits;
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] evt_q;
  logic         latch_clr;

  stsreg_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  stsreg_edge #(.W(W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_q),
    .live_in   (cond_in),
    .rise_en   (rise_q),
    .fall_en   (fall_q),
    .live_m    (live_m),
    .hist_q    (hist_q),
    .rise_hits (rise_hits),
    .fall_hits (fall_hits)
  );

  stsreg_latch #(.W(W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_q),
    .set_bits (rise_hits | fall_hits),
    .clr      (latch_clr),
    .evt_q    (evt_q)
  );

  stsreg_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .part_sel  (part_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .live_m    (live_m),
    .evt_q     (evt_q),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .mask_q    (mask_q),
    .latch_clr (latch_clr),
    .rd_data   (rd_data)
  );

  assign sum_out = |(evt_q & mask_q);

endmodule

// File: rtl/stsreg_chk.sv
module stsreg_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_q,
  input logic [W-1:0] cond_in,
  input logic [2:0]   part_sel,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         sum_out,
  input logic [W-1:0] evt_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] rise_hits,
  input logic [W-1:0] fall_hits
);

  localparam logic [W-1:0] VALID = {1'b0, {(W-1){1'b1}}};

  p_top_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_data[W-1] && !evt_q[W-1]);

  p_live_read_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && part_sel == 3'd0) |=> rd_data == $past(cond_in & VALID));

  p_event_source_r8: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (evt_q & ~($past(evt_q) | $past(rise_hits | fall_hits))) == '0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !(rd_en && part_sel == 3'd3) |=> (evt_q & $past(evt_q)) == $past(evt_q));

  p_clear_read_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && part_sel == 3'd3) |=> rd_data == $past(evt_q));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (mask_q == '0) |-> !sum_out);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> $stable(rd_data));

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && part_sel > 3'd4) |=> rd_data == '0);

endmodule

bind stsreg_cell stsreg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .cond_in   (cond_in),
  .part_sel  (part_sel),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .sum_out   (sum_out),
  .evt_q     (evt_q),
  .mask_q    (mask_q),
  .rise_hits (rise_hits),
  .fall_hits (fall_hits)
);

// File: tb/tb_stsreg_cell.sv
`timescale 1ns/1ps
module tb_stsreg_cell;

  logic        clk;
  logic        rst_n;
  logic [15:0] cond_in;
  logic [2:0]  part_sel;
  logic        wr_en;
  logic        rd_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        sum_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [15:0] m_hist, m_evt, m_rise, m_fall, m_mask, m_rd;

  stsreg_cell dut (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .part_sel(part_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .sum_out(sum_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: one update per rising edge
  always @(posedge clk) begin
    logic [15:0] cin, edges, rv;
    if (!rst_n) begin
      m_hist = 0; m_evt = 0; m_rise = 16'h7FFF; m_fall = 0; m_mask = 0; m_rd = 0;
    end else begin
      cin   = cond_in & 16'h7FFF;
      edges = (cin & ~m_hist & m_rise) | (~cin & m_hist & m_fall);
      rv = 0;
      if (part_sel == 0) rv = cin;
      if (part_sel == 1) rv = m_rise;
      if (part_sel == 2) rv = m_fall;
      if (part_sel == 3) rv = m_evt;
      if (part_sel == 4) rv = m_mask;
      if (rd_en) m_rd = rv;
      if (rd_en && part_sel == 3) m_evt = 0;
      m_evt = m_evt | edges;
      if (wr_en && part_sel == 1) m_rise = wr_data & 16'h7FFF;
      if (wr_en && part_sel == 2) m_fall = wr_data & 16'h7FFF;
      if (wr_en && part_sel == 4) m_mask = wr_data & 16'h7FFF;
      m_hist = cin;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R12 rd_data vs model", rd_data, m_rd);
      check("R10 sum_out vs model", {15'd0, sum_out}, {15'd0, |(m_evt & m_mask)});
    end
  end

  task automatic rd(input logic [2:0] sel, output logic [15:0] v);
    part_sel = sel; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    part_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input logic [15:0] c);
    cond_in = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; cond_in = 0; part_sel = 0; wr_en = 0; rd_en = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R11 reset values
    check("R11 sum after reset", {15'd0, sum_out}, 16'h0000);
    rd(1, v); check("R11 rising filter reset", v, 16'h7FFF);
    rd(2, v); check("R11 falling filter reset", v, 16'h0000);
    rd(4, v); check("R11 enable reset", v, 16'h0000);
    rd(3, v); check("R11 event reset", v, 16'h0000);

    // R1 / R9 enable write, bit 15 dropped
    wr(4, 16'hFFFF);
    rd(4, v); check("R1 enable bit15 dropped", v, 16'h7FFF);
    rd(4, v); check("R9 enable reread unchanged", v, 16'h7FFF);

    // R2 live part read-only, follows input
    wr(0, 16'h1234);
    rd(0, v); check("R2 live ignores write", v, 16'h0000);
    step(16'h00F0);
    rd(0, v); check("R2 live follows input", v, 16'h00F0);
    check("R10 summary on enabled event", {15'd0, sum_out}, 16'h0001);
    rd(3, v); check("R3 rising edges latched", v, 16'h00F0);
    rd(3, v); check("R7 event cleared by read", v, 16'h0000);

    // R8 event not writable
    wr(3, 16'h0F00);
    rd(3, v); check("R8 event write ignored", v, 16'h0000);

    // R4 falling filter, R3 rising blocked
    wr(2, 16'h00F0);
    wr(1, 16'h0000);
    step(16'h0000);
    rd(3, v); check("R4 falling edges latched", v, 16'h00F0);
    step(16'h00F0);
    rd(3, v); check("R3 rising blocked when filter clear", v, 16'h0000);

    // R5 both edges
    wr(1, 16'h0001);
    wr(2, 16'h0001);
    step(16'h00F1);
    rd(3, v); check("R5 both: rising recorded", v, 16'h0001);
    step(16'h00F0);
    rd(3, v); check("R5 both: falling recorded", v, 16'h0001);

    // R6 sticky, R10 masking
    step(16'h00F1);
    repeat (5) @(negedge clk);
    wr(4, 16'h0000);
    check("R10 summary masked off", {15'd0, sum_out}, 16'h0000);
    wr(4, 16'h0001);
    check("R10 summary masked on", {15'd0, sum_out}, 16'h0001);
    rd(3, v); check("R6 event held until read", v, 16'h0001);

    // R7 edge in the clearing cycle survives
    cond_in = 16'h00F0;
    rd(3, v); check("R7 clearing read value", v, 16'h0000);
    rd(3, v); check("R7 edge in clear cycle kept", v, 16'h0001);

    // R1 bit 15 never stored or latched
    wr(1, 16'hFFFF);
    rd(1, v); check("R1 rising filter bit15 dropped", v, 16'h7FFF);
    step(16'h80F0);
    rd(0, v); check("R1 live bit15 reads zero", v, 16'h00F0);
    rd(3, v); check("R1 no event from bit15", v, 16'h0000);

    // R12 reserved selects
    wr(6, 16'h1234);
    rd(5, v); check("R12 reserved reads zero", v, 16'h0000);
    rd(4, v); check("R12 reserved write ignored", v, 16'h0001);
    repeat (3) @(negedge clk);
    check("R12 rd_data holds", rd_data, 16'h0001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule